// File: doc/BRIEF.md
# Probabilistic Adjacent Row Refresher

This block sits beside the command path of a DRAM controller and defends against disturbance errors caused by repeatedly opening and closing one row. Every time the controller closes an ordinary row, the block makes one biased random draw. With probability p, set by a programmable threshold, it queues an extra open-then-close of one of the two rows that physically border the closed row. Each border row is picked with equal chance, so each is refreshed with probability p/2 per close. The block keeps no per-row activation counts and no history of addresses. The only per-bank storage is one pending neighbour request.

Randomness comes from a free-running 16-bit maximal-length LFSR. A draw hits when the current LFSR value, read as an unsigned number, is below the threshold. A typical setting is p = 0.001, which is a threshold of about 66 on the 2^16 scale. The main scheduler sees a single request port carrying a command, a bank and a row. It grants a command slot with a one-cycle strobe. The close that ends an extra refresh is reported with a flag so that it does not start a new draw.

Top module: `adj_row_refresher`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `reqValid` is low.
- R2: An ordinary close (`closeValid`=1, `closeExtra`=0) hits when the LFSR value is below `threshold`. A threshold of 0 never hits and a threshold of 2^16 always hits. A hit shows on the request port in the cycle after the close.
- R3: A hit on row r away from the array edges requests row r-1 or r+1. One LFSR bit picks the side, and over many hits both sides occur in roughly equal numbers.
- R4: A hit on row 0 always requests row 1. A hit on the last row (all ones) always requests the row below it.
- R5: A close with `closeExtra`=1 makes no draw and queues nothing, whatever the threshold.
- R6: A queued refresh is first offered with `reqCmd`=0 (activate). Once that is granted, the same bank and row are offered with `reqCmd`=1 (precharge). Once the precharge is granted, the entry is freed.
- R7: A new hit for a bank whose entry still waits for its activate replaces that entry's row. A hit for a bank whose entry waits for its precharge is dropped, and so is a hit that arrives in the same cycle as a grant to that bank.
- R8: An entry waiting for its precharge is offered before any activate. Among activates, the lowest bank index goes first.
- R9: Over many closes the hit rate follows threshold/2^16. With threshold 2^14, 400 closes give between 50 and 150 hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| closeValid | input | 1 | A row close (precharge) is issued this cycle |
| closeExtra | input | 1 | The close ends an extra neighbour refresh; no draw |
| closeBank | input | 2 | Bank of the closed row |
| closeRow | input | 8 | Row address being closed |
| threshold | input | 17 | Hit threshold, p times 2^16 |
| grant | input | 1 | Scheduler accepts the offered command this cycle |
| reqValid | output | 1 | A neighbour-refresh command is offered |
| reqCmd | output | 1 | 0 = activate, 1 = precharge |
| reqBank | output | 2 | Bank of the offered command |
| reqRow | output | 8 | Neighbour row of the offered command |

## Verification
The assertions assume that `grant` is raised only while `reqValid` is high. They also assume that the close that ends an extra refresh carries `closeExtra`, and that the threshold does not change on a cycle of interest. The bench drives every input on the falling edge and pulses `grant` only when a request is offered. It holds the threshold steady within each scenario, so the checks on adjacency and ordering see a legal command stream. The statistical checks on side balance and hit rate vary the spacing between closes so that the LFSR is not sampled at a fixed stride.

// File: rtl/adj_refresh_pkg.sv
package adj_refresh_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_ACT  = 2'd1,
    SLOT_PRE  = 2'd2
  } slotState_t;

  typedef struct packed {
    logic load;
    logic pickUpper;
  } drawStrobe_t;
endpackage

// File: rtl/adj_refresh_lfsr.sv
module adj_refresh_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 1
) (
  input  logic         clk,
  input  logic         rstN,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (!rstN) value <= SEED;
    else if (value[0]) value <= (value >> 1) ^ TAPS;
    else value <= value >> 1;
  end

  lfsr_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    value != '0);
endmodule

// File: rtl/adj_refresh_ctrl.sv
module adj_refresh_ctrl
  import adj_refresh_pkg::*;
#(
  parameter int LFSR_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            closeValid,
  input  logic            closeExtra,
  input  logic [LFSR_W:0] threshold,
  output drawStrobe_t     strobe
);
  logic [LFSR_W-1:0] lfsrVal;
  logic              hit;

  adj_refresh_lfsr #(.W(LFSR_W)) u_lfsr (
    .clk  (clk),
    .rstN (rstN),
    .value(lfsrVal)
  );

  assign hit = {1'b0, lfsrVal} < threshold;

  always_comb begin
    strobe.load      = closeValid && !closeExtra && hit;
    strobe.pickUpper = lfsrVal[0];
  end

  // R5
  extra_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    (closeValid && closeExtra) |-> !strobe.load);
  // R2
  zero_thresh_chk: assert property (@(posedge clk) disable iff (!rstN)
    (threshold == '0) |-> !strobe.load);
  // R2
  full_thresh_chk: assert property (@(posedge clk) disable iff (!rstN)
    (closeValid && !closeExtra && threshold[LFSR_W]) |-> strobe.load);
endmodule

// File: rtl/adj_refresh_dp.sv
module adj_refresh_dp
  import adj_refresh_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  drawStrobe_t       strobe,
  input  logic [BANK_W-1:0] closeBank,
  input  logic [ROW_W-1:0]  closeRow,
  input  logic              grant,
  output logic              reqValid,
  output logic              reqCmd,
  output logic [BANK_W-1:0] reqBank,
  output logic [ROW_W-1:0]  reqRow
);
  localparam logic [ROW_W-1:0] ROW_LAST = '1;

  slotState_t        slotState [NUM_BANKS];
  logic [ROW_W-1:0]  slotRow   [NUM_BANKS];
  logic [ROW_W-1:0]  nbrRow;
  logic [NUM_BANKS-1:0] preVec;

  always_comb begin
    if (closeRow == '0) nbrRow = ROW_W'(1);
    else if (closeRow == ROW_LAST) nbrRow = ROW_LAST - ROW_W'(1);
    else if (strobe.pickUpper) nbrRow = closeRow + ROW_W'(1);
    else nbrRow = closeRow - ROW_W'(1);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_slot
    slotState_t       st;
    logic [ROW_W-1:0] rw;
    logic             granted;

    assign granted = grant && reqValid && (reqBank == BANK_W'(b));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        st <= SLOT_IDLE;
        rw <= '0;
      end else if (granted) begin
        st <= (st == SLOT_ACT) ? SLOT_PRE : SLOT_IDLE;
      end else if (strobe.load && closeBank == BANK_W'(b) && st != SLOT_PRE) begin
        st <= SLOT_ACT;
        rw <= nbrRow;
      end
    end

    assign slotState[b] = st;
    assign slotRow[b]   = rw;
    assign preVec[b]    = (st == SLOT_PRE);
  end

  always_comb begin
    logic              preFound, actFound;
    logic [BANK_W-1:0] preIdx, actIdx, selIdx;
    preFound = 1'b0;
    actFound = 1'b0;
    preIdx   = '0;
    actIdx   = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (slotState[b] == SLOT_PRE) begin
        preFound = 1'b1;
        preIdx   = BANK_W'(b);
      end
      if (slotState[b] == SLOT_ACT) begin
        actFound = 1'b1;
        actIdx   = BANK_W'(b);
      end
    end
    selIdx   = preFound ? preIdx : actIdx;
    reqValid = preFound || actFound;
    reqCmd   = preFound;
    reqBank  = selIdx;
    reqRow   = slotRow[selIdx];
  end

  // R6
  act_then_pre_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && grant && !reqCmd) |=>
      (reqValid && reqCmd && reqBank == $past(reqBank) && reqRow == $past(reqRow)));
  // R8
  single_pre_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(preVec));
  // R4
  low_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && closeRow == '0 && slotState[closeBank] == SLOT_IDLE) |=>
      (slotRow[$past(closeBank)] == ROW_W'(1)));
  // R4
  high_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && closeRow == ROW_LAST && slotState[closeBank] == SLOT_IDLE) |=>
      (slotRow[$past(closeBank)] == ROW_LAST - ROW_W'(1)));
  // R3
  nbr_adjacent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && slotState[closeBank] == SLOT_IDLE) |=>
      ((slotRow[$past(closeBank)] - $past(closeRow)) == ROW_W'(1) ||
       ($past(closeRow) - slotRow[$past(closeBank)]) == ROW_W'(1)));
endmodule

// File: rtl/adj_row_refresher.sv
module adj_row_refresher
  import adj_refresh_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  parameter int LFSR_W    = 16,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              closeValid,
  input  logic              closeExtra,
  input  logic [BANK_W-1:0] closeBank,
  input  logic [ROW_W-1:0]  closeRow,
  input  logic [LFSR_W:0]   threshold,
  input  logic              grant,
  output logic              reqValid,
  output logic              reqCmd,
  output logic [BANK_W-1:0] reqBank,
  output logic [ROW_W-1:0]  reqRow
);
  drawStrobe_t strobe;

  adj_refresh_ctrl #(.LFSR_W(LFSR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .closeValid(closeValid),
    .closeExtra(closeExtra),
    .threshold (threshold),
    .strobe    (strobe)
  );

  adj_refresh_dp #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .closeBank(closeBank),
    .closeRow (closeRow),
    .grant    (grant),
    .reqValid (reqValid),
    .reqCmd   (reqCmd),
    .reqBank  (reqBank),
    .reqRow   (reqRow)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> !reqValid);
endmodule

// File: tb/adj_row_refresher_bench.sv
`timescale 1ns/1ps
module adj_row_refresher_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        closeValid = 1'b0;
  logic        closeExtra = 1'b0;
  logic [1:0]  closeBank = '0;
  logic [7:0]  closeRow = '0;
  logic [16:0] threshold = '0;
  logic        grant = 1'b0;
  logic        reqValid, reqCmd;
  logic [1:0]  reqBank;
  logic [7:0]  reqRow;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  adj_row_refresher u_adj_row_refresher (
    .clk(clk), .rstN(rstN), .closeValid(closeValid), .closeExtra(closeExtra),
    .closeBank(closeBank), .closeRow(closeRow), .threshold(threshold),
    .grant(grant), .reqValid(reqValid), .reqCmd(reqCmd),
    .reqBank(reqBank), .reqRow(reqRow)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doClose(input int bank, input int row, input bit extra);
    @(negedge clk);
    closeValid = 1'b1; closeExtra = extra;
    closeBank = 2'(bank); closeRow = 8'(row);
    @(negedge clk);
    closeValid = 1'b0; closeExtra = 1'b0;
  endtask

  task automatic doGrant();
    grant = 1'b1;
    @(negedge clk);
    grant = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 16 && reqValid; i++) doGrant();
  endtask

  task automatic testReset();
    check(!reqValid, "R1 idle after reset", reqValid, 0);
  endtask

  task automatic testZeroThreshold();
    int seen = 0;
    threshold = 17'd0;
    for (int i = 0; i < 50; i++) begin
      doClose(i % 4, 30 + i, 1'b0);
      if (reqValid) seen++;
    end
    check(seen == 0, "R2 zero threshold never hits", seen, 0);
  endtask

  task automatic testHitAndSequence();
    threshold = 17'h10000;
    doClose(1, 10, 1'b0);
    check(reqValid && reqBank == 2'd1 && !reqCmd, "R2 full threshold hit, R6 act first",
          {reqValid, reqCmd, reqBank}, 3'b101 << 0);
    check(reqRow == 8'd9 || reqRow == 8'd11, "R3 neighbour of row 10", reqRow, 11);
    begin
      int r = reqRow;
      doGrant();
      check(reqValid && reqCmd && reqBank == 2'd1 && reqRow == 8'(r),
            "R6 precharge same row", reqRow, r);
      doGrant();
      check(!reqValid, "R6 entry freed", reqValid, 0);
    end
  endtask

  task automatic testEdges();
    threshold = 17'h10000;
    for (int i = 0; i < 4; i++) begin
      doClose(i, 0, 1'b0);
      check(reqRow == 8'd1, "R4 row 0 maps to row 1", reqRow, 1);
      drain();
      doClose(i, 255, 1'b0);
      check(reqRow == 8'd254, "R4 last row maps down", reqRow, 254);
      drain();
    end
  endtask

  task automatic testExtraClose();
    threshold = 17'h10000;
    for (int i = 0; i < 8; i++) begin
      doClose(i % 4, 77, 1'b1);
      check(!reqValid, "R5 extra close makes no draw", reqValid, 0);
    end
  endtask

  task automatic testOverwrite();
    threshold = 17'h10000;
    doClose(2, 20, 1'b0);
    doClose(2, 100, 1'b0);
    check(reqBank == 2'd2 && (reqRow == 8'd99 || reqRow == 8'd101),
          "R7 act-waiting entry overwritten", reqRow, 101);
    drain();
    doClose(0, 50, 1'b0);
    begin
      int r = reqRow;
      doGrant();
      doClose(0, 200, 1'b0);
      check(reqValid && reqCmd && reqBank == 2'd0 && reqRow == 8'(r),
            "R7 pre-waiting hit dropped", reqRow, r);
      doGrant();
      check(!reqValid, "R7 nothing left after drop", reqValid, 0);
    end
  endtask

  task automatic testPriority();
    threshold = 17'h10000;
    doClose(3, 40, 1'b0);
    doClose(1, 60, 1'b0);
    check(reqBank == 2'd1 && !reqCmd, "R8 lowest bank activate first", reqBank, 1);
    doGrant();
    check(reqBank == 2'd1 && reqCmd, "R8 precharge before other activate", reqBank, 1);
    doGrant();
    check(reqBank == 2'd3 && !reqCmd && (reqRow == 8'd39 || reqRow == 8'd41),
          "R8 next bank served", reqBank, 3);
    drain();
  endtask

  task automatic testSideBalance();
    int upper = 0, wrong = 0;
    threshold = 17'h10000;
    for (int i = 0; i < 200; i++) begin
      for (int g = 0; g < i % 5; g++) @(negedge clk);
      doClose(0, 100, 1'b0);
      if (reqRow == 8'd101) upper++;
      else if (reqRow != 8'd99) wrong++;
      drain();
    end
    check(wrong == 0, "R3 only adjacent rows", wrong, 0);
    check(upper >= 50 && upper <= 150, "R3 sides roughly equal", upper, 100);
  endtask

  task automatic testRate();
    int hits = 0;
    threshold = 17'h04000;
    for (int i = 0; i < 400; i++) begin
      for (int g = 0; g < i % 7; g++) @(negedge clk);
      doClose(i % 4, 128, 1'b0);
      if (reqValid) hits++;
      drain();
    end
    check(hits >= 50 && hits <= 150, "R9 hit rate near one quarter", hits, 100);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(!reqValid, "R1 idle during reset", reqValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testZeroThreshold();
    testHitAndSequence();
    testEdges();
    testExtraClose();
    testOverwrite();
    testPriority();
    testSideBalance();
    testRate();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule